// File: doc/BRIEF.md
# Row-Synchronised Feedback DAC Driver

This block drives a 14-bit parallel feedback DAC in step with a row multiplexer. Each time the multiplexer switches to a new row, the block waits a programmable number of clock cycles so the switch can settle. It then presents the feedback word for the newly active row on the DAC bus and pulses a one-cycle latch strobe. The same settling delay applies to every row.

The rows are not visited in index order. A sequence pointer counts row switches within a frame. A frame-start strobe clears the pointer, and the pointer wraps at a programmable row count. A row-order table translates the sequence position into an index within the feedback table. Feedback words are held in two banks. A select flag marks which bank is currently valid, and the block reads only that bank while the other one is being refilled elsewhere.

Top module: `row_fb_dac`

## Requirements
- R1: While reset is asserted, and after its release until the first update, `dacData` is zero and `dacLatch` is low.
- R2: When `rowSwitch` is sampled high at clock edge E and no further switch follows, `dacData` takes its new value at edge E+D+1, where D is the delay. `dacLatch` is high for exactly the one cycle that follows that edge.
- R3: The delay D is the value of `delayCfg` sampled at the row-switch edge. Any change to `delayCfg` while the wait is running has no effect on that wait.
- R4: The applied word is entry `orderTable[p*IDX_W +: IDX_W]` of the valid bank, where p is the sequence position of the switch. Bank entry i sits at bits `[i*DATA_W +: DATA_W]` of `bank0Data` or `bank1Data`.
- R5: `bankSel` is sampled at the edge where the update happens. A value of 0 selects `bank0Data` and a value of 1 selects `bank1Data`. A change of `bankSel` during the wait is therefore honoured.
- R6: `frameStart` resets the sequence pointer to position 0. A row switch in the same cycle as `frameStart` applies position 0. A `frameStart` on its own makes the next switch apply position 0.
- R7: After applying position p, the pointer moves to p+1. It wraps to 0 once p+1 reaches `rowCount` or `ROWS`. A `rowCount` of 0 or 1 keeps every switch at position 0.
- R8: A `rowSwitch` that arrives while a wait is pending restarts the wait for the new row. The superseded row's word is never output, and there is no latch pulse in the cycle after any switch.
- R9: Between updates, `dacData` holds its value and `dacLatch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rstN | input | 1 | Asynchronous active-low reset |
| rowSwitch | input | 1 | One-cycle strobe marking a multiplexer row change |
| frameStart | input | 1 | One-cycle strobe marking the start of a frame |
| bankSel | input | 1 | Selects the valid feedback bank (0 or 1) |
| delayCfg | input | DLY_W (8) | Settling delay, in clock cycles, after each switch |
| rowCount | input | CNT_W (4) | Number of rows in the sequence |
| orderTable | input | ROWS*IDX_W (24) | Bank index for each sequence position |
| bank0Data | input | ROWS*DATA_W (112) | Feedback words of bank 0 |
| bank1Data | input | ROWS*DATA_W (112) | Feedback words of bank 1 |
| dacData | output | DATA_W (14) | Parallel DAC data word |
| dacLatch | output | 1 | One-cycle strobe that latches `dacData` into the DAC |

## Verification
A row switch sampled at edge E with delay D produces its word and latch pulse at edge E+D+1. The bench drives its strobes just after one falling edge and samples on each later falling edge. It checks that the old word is held with the latch low for D+1 samples, that the new word appears with the latch high on the next sample, and that the latch is low again one sample after that. For a restarted wait, the count begins again from the second switch, and the bench checks the late window for any stray pulse. The bank select and the delay register are changed right after the switch, so the sampling point of each input is checked by the word that appears and by the cycle in which it appears.

// File: rtl/row_fb_dac_pkg.sv
package row_fb_dac_pkg;

  // Strobes from the sequencing control to the output datapath.
  typedef struct packed {
    logic capture;  // row switch: latch the bank index of the new position
    logic fire;     // settling wait over: drive the word onto the DAC
  } dacStrobe_t;

endpackage

// File: rtl/row_fb_dac_ctrl.sv
module row_fb_dac_ctrl
  import row_fb_dac_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(ROWS),
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rowSwitch,
  input  logic             frameStart,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic [CNT_W-1:0] rowCount,
  output logic [IDX_W-1:0] launchPos,
  output dacStrobe_t       strobe,
  output logic             waitBusy
);

  logic [IDX_W-1:0] seqPtr;
  logic [DLY_W-1:0] waitCnt;
  logic             pending;
  logic [CNT_W-1:0] nxtCnt;
  logic             wrapNow;

  always_comb begin
    launchPos      = frameStart ? '0 : seqPtr;
    nxtCnt         = CNT_W'(launchPos) + CNT_W'(1);
    wrapNow        = (nxtCnt >= rowCount) || (nxtCnt == CNT_W'(ROWS));
    strobe.capture = rowSwitch;
    // a switch in the same cycle supersedes the pending update
    strobe.fire    = pending && (waitCnt == '0) && !rowSwitch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqPtr  <= '0;
      waitCnt <= '0;
      pending <= 1'b0;
    end else if (rowSwitch) begin
      pending <= 1'b1;
      waitCnt <= delayCfg;
      seqPtr  <= wrapNow ? '0 : nxtCnt[IDX_W-1:0];
    end else begin
      if (frameStart) seqPtr <= '0;
      if (pending) begin
        if (waitCnt == '0) pending <= 1'b0;
        else               waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  assign waitBusy = pending;

endmodule

// File: rtl/row_fb_dac_path.sv
module row_fb_dac_path
  import row_fb_dac_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int DATA_W = 14,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dacStrobe_t             strobe,
  input  logic [IDX_W-1:0]       launchPos,
  input  logic                   bankSel,
  input  logic [ROWS*IDX_W-1:0]  orderTable,
  input  logic [ROWS*DATA_W-1:0] bank0Data,
  input  logic [ROWS*DATA_W-1:0] bank1Data,
  output logic [DATA_W-1:0]      dacData,
  output logic                   dacLatch
);

  logic [IDX_W-1:0]  orderArr [ROWS];
  logic [DATA_W-1:0] bank0Arr [ROWS];
  logic [DATA_W-1:0] bank1Arr [ROWS];
  logic [IDX_W-1:0]  activeIdx;

  for (genvar g = 0; g < ROWS; g++) begin : g_unpack
    assign orderArr[g] = orderTable[g*IDX_W +: IDX_W];
    assign bank0Arr[g] = bank0Data[g*DATA_W +: DATA_W];
    assign bank1Arr[g] = bank1Data[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIdx <= '0;
      dacData   <= '0;
      dacLatch  <= 1'b0;
    end else begin
      if (strobe.capture) activeIdx <= orderArr[launchPos];
      dacLatch <= strobe.fire;
      if (strobe.fire) dacData <= bankSel ? bank1Arr[activeIdx] : bank0Arr[activeIdx];
    end
  end

endmodule

// File: rtl/row_fb_dac.sv
module row_fb_dac
  import row_fb_dac_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int DATA_W = 14,
  parameter int DLY_W  = 8,
  localparam int IDX_W = $clog2(ROWS),
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rowSwitch,
  input  logic                   frameStart,
  input  logic                   bankSel,
  input  logic [DLY_W-1:0]       delayCfg,
  input  logic [CNT_W-1:0]       rowCount,
  input  logic [ROWS*IDX_W-1:0]  orderTable,
  input  logic [ROWS*DATA_W-1:0] bank0Data,
  input  logic [ROWS*DATA_W-1:0] bank1Data,
  output logic [DATA_W-1:0]      dacData,
  output logic                   dacLatch
);

  dacStrobe_t       strobe;
  logic [IDX_W-1:0] launchPos;
  logic             waitBusy;

  row_fb_dac_ctrl #(.ROWS(ROWS), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowSwitch(rowSwitch), .frameStart(frameStart),
    .delayCfg(delayCfg), .rowCount(rowCount), .launchPos(launchPos),
    .strobe(strobe), .waitBusy(waitBusy)
  );

  row_fb_dac_path #(.ROWS(ROWS), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .launchPos(launchPos),
    .bankSel(bankSel), .orderTable(orderTable), .bank0Data(bank0Data),
    .bank1Data(bank1Data), .dacData(dacData), .dacLatch(dacLatch)
  );

endmodule

// File: rtl/row_fb_dac_chk.sv
module row_fb_dac_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              rowSwitch,
  input logic              waitBusy,
  input logic [DATA_W-1:0] dacData,
  input logic              dacLatch
);

  // R1: one edge after reset is seen, the outputs are cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (dacData == '0 && !dacLatch));

  // R2: the latch is a single-cycle pulse
  p_latch_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    dacLatch |=> !dacLatch);

  // R2: an update only follows a pending wait in the control
  p_latch_after_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    dacLatch |-> $past(waitBusy));

  // R8: a switch suppresses any update at the following edge
  p_switch_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    rowSwitch |=> !dacLatch);

  // R9: the data bus only moves together with the latch
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dacLatch |-> $stable(dacData));

endmodule

bind row_fb_dac row_fb_dac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rowSwitch(rowSwitch), .waitBusy(waitBusy),
  .dacData(dacData), .dacLatch(dacLatch)
);

// File: tb/tb_row_fb_dac.sv
module tb_row_fb_dac;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 8;
  localparam int DATA_W = 14;
  localparam int DLY_W  = 8;
  localparam int IDX_W  = $clog2(ROWS);
  localparam int CNT_W  = $clog2(ROWS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowSwitch = 1'b0, frameStart = 1'b0, bankSel = 1'b0;
  logic [DLY_W-1:0] delayCfg = '0;
  logic [CNT_W-1:0] rowCount = '0;
  logic [ROWS*IDX_W-1:0] orderTable;
  logic [ROWS*DATA_W-1:0] bank0Data, bank1Data;
  logic [DATA_W-1:0] dacData;
  logic dacLatch;

  int checks = 0, errors = 0, mPos = 0;
  logic [DATA_W-1:0] lastVal = '0;

  row_fb_dac #(.ROWS(ROWS), .DATA_W(DATA_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rstN(rstN), .rowSwitch(rowSwitch), .frameStart(frameStart),
    .bankSel(bankSel), .delayCfg(delayCfg), .rowCount(rowCount),
    .orderTable(orderTable), .bank0Data(bank0Data), .bank1Data(bank1Data),
    .dacData(dacData), .dacLatch(dacLatch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int idxOf(input int pos);
    return (pos * 3 + 1) % ROWS;
  endfunction

  function automatic logic [DATA_W-1:0] valOf(input int idx, input bit bank);
    return bank ? DATA_W'(14'h2000 + idx * 37) : DATA_W'(idx * 101 + 5);
  endfunction

  function automatic int wrapNext(input int p);
    int n = p + 1;
    if (n >= int'(rowCount) || n == ROWS) return 0;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One switch with delay d; the bank and delay inputs are altered right after
  // the switch so that the sampling point of each is exercised (R3, R5).
  task automatic doSwitch(input bit frame, input int d, input bit bank, input string req);
    int p;
    logic [DATA_W-1:0] e;
    @(negedge clk);
    frameStart = frame; rowSwitch = 1'b1; delayCfg = DLY_W'(d); bankSel = ~bank;
    p = frame ? 0 : mPos;
    mPos = wrapNext(p);
    @(negedge clk);
    frameStart = 1'b0; rowSwitch = 1'b0; delayCfg = DLY_W'(d + 3); bankSel = bank;
    for (int i = 0; i < d + 1; i++) begin
      chk({req, " R3 wait latch"}, dacLatch, 0);
      chk("R9 hold data", dacData, lastVal);
      @(negedge clk);
    end
    e = valOf(idxOf(p), bank);
    chk({req, " R5 value"}, dacData, e);
    chk("R2 latch high", dacLatch, 1);
    lastVal = e;
    @(negedge clk);
    chk("R2 latch pulse end", dacLatch, 0);
  endtask

  initial begin
    int p2;
    for (int k = 0; k < ROWS; k++) begin
      orderTable[k*IDX_W +: IDX_W] = IDX_W'(idxOf(k));
      bank0Data[k*DATA_W +: DATA_W] = valOf(k, 1'b0);
      bank1Data[k*DATA_W +: DATA_W] = valOf(k, 1'b1);
    end
    repeat (3) @(negedge clk);
    chk("R1 reset data", dacData, 0);
    chk("R1 reset latch", dacLatch, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 post-reset data", dacData, 0);
    chk("R1 post-reset latch", dacLatch, 0);

    // five-row sequence over two frames, varied delays and banks
    rowCount = CNT_W'(5);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 7; s++)
        doSwitch(s == 0, (s + f) % 6, 1'((s + f) % 2), "R4 R7 five rows");

    // full eight-row sequence with wrap
    rowCount = CNT_W'(8);
    doSwitch(1'b1, 3, 1'b1, "R4 R6 full frame");
    for (int s = 0; s < 9; s++) doSwitch(1'b0, 1, 1'b0, "R4 R7 full wrap");

    // zero row count keeps position 0
    rowCount = '0;
    doSwitch(1'b0, 2, 1'b0, "R7 zero rows");
    doSwitch(1'b0, 2, 1'b1, "R7 zero rows");

    // frame start alone resets the pointer
    rowCount = CNT_W'(5);
    doSwitch(1'b0, 0, 1'b0, "R6 setup");
    doSwitch(1'b0, 0, 1'b0, "R6 setup");
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    mPos = 0;
    chk("R6 no update on frame start", dacLatch, 0);
    doSwitch(1'b0, 1, 1'b1, "R6 frame reset");

    // restart of a pending wait
    rowCount = CNT_W'(8);
    @(negedge clk);
    rowSwitch = 1'b1; delayCfg = DLY_W'(6); bankSel = 1'b0;
    mPos = wrapNext(mPos);
    @(negedge clk); rowSwitch = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 first wait latch", dacLatch, 0);
      @(negedge clk);
    end
    rowSwitch = 1'b1; delayCfg = DLY_W'(2);
    p2 = mPos;
    mPos = wrapNext(mPos);
    @(negedge clk); rowSwitch = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 restarted wait latch", dacLatch, 0);
      chk("R8 stale data held", dacData, lastVal);
      @(negedge clk);
    end
    chk("R8 new row value", dacData, valOf(idxOf(p2), 1'b0));
    chk("R8 latch high", dacLatch, 1);
    lastVal = valOf(idxOf(p2), 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 no late pulse", dacLatch, 0);
      chk("R9 data stays", dacData, lastVal);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule